// File: doc/BRIEF.md
# Indirect Register Port Decoder

This block is the host-side front end for register access in a network controller. Each access arrives as a single-cycle strobe. The strobe carries a 5-bit byte offset into a 32-byte I/O window, active-low byte enables, a direction bit and write data. The block decodes the access against the legal set for the current I/O width. It then serves one of the following:

- a 16-byte station address PROM;
- a pointer register;
- a data port into a control register file, indexed by the pointer;
- a second data port into a bus-configuration register file, indexed by the same pointer;
- a reset register.

The block starts in 16-bit mode. It moves to 32-bit mode only when a doubleword write lands on the control data port. After that, only a reset returns it to 16-bit mode. A reset can be the hardware reset or a read of the reset register, which is a software reset. The two register files are small internal arrays. They stand in for the real files and have no side effects.

Top module: `hostreg_window`

## Requirements
- R1: After reset, `dw_mode`, `rd_valid`, `bad_access` and `soft_reset` are 0, and the pointer reads 0.
- R2: In 16-bit mode, a read at offset 00h–0Fh with exactly one enable low is legal only if the low enable matches offset bits [1:0]. It returns PROM byte number offset[3:2]*4+lane on byte lane `lane` (bits 8*lane+7:8*lane), with 0 on the other lanes. Byte k of the PROM resets to PROM_BASE+k, where the default PROM_BASE is A0h.
- R3: In 16-bit mode, PROM half-word reads and writes are legal with enables 1100 at offsets ending in 00b, or enables 0011 at offsets ending in 10b. They read or write the two PROM bytes on the enabled lanes.
- R4: In 16-bit mode, the pointer sits at 12h on the upper lanes, enables 0011, data bits [31:16]. The control data port sits at 10h on the lower lanes, enables 1100. The port reads and writes control register[pointer].
- R5: The configuration data port (16h with enables 0011 in 16-bit mode, 1Ch in 32-bit mode) accesses configuration register[pointer]. In entry 18, bit 7 always reads the current `dw_mode`, and a write to that bit has no effect.
- R6: In 16-bit mode, a write at 10h with enables 0000 is legal. It writes the control register and sets `dw_mode`, which is visible the cycle after the strobe.
- R7: In 32-bit mode, only enables 0000 at offsets ending in 00b are legal. The data port is at 10h, the pointer at 14h, the reset register at 18h and the configuration port at 1Ch, all using data bits [15:0]. PROM reads at 00h–0Ch return four bytes.
- R8: Once set, `dw_mode` stays set through legal and illegal accesses, including a write of the stop bit (bit 2) to control register 0. A 16-bit style access in 32-bit mode is illegal.
- R9: A legal read of the reset register gives a one-cycle `soft_reset`. It clears the pointer, `dw_mode` and both register files, and leaves the PROM unchanged. A write to the reset register has no effect.
- R10: An access outside the legal set raises `bad_access` for one cycle. Its write changes no state, and its read returns 0.
- R11: `rd_data`, `rd_valid`, `bad_access` and `soft_reset` are registered and describe the access strobed in the previous cycle. Back-to-back accesses are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 5 | Byte offset within the 32-byte window |
| acc_be_n | input | 4 | Active-low byte enables |
| acc_wdata | input | 32 | Write data, byte-lane aligned |
| rd_data | output | 32 | Read data of the previous access |
| rd_valid | output | 1 | Previous access was a read |
| bad_access | output | 1 | Previous access was illegal |
| soft_reset | output | 1 | Previous access was a reset register read |
| dw_mode | output | 1 | 32-bit I/O mode in force |

## Verification
Wrong internal state shows up at the ports one cycle later:

- A corrupted pointer appears on the next pointer read.
- A corrupted pointer also sends data-port reads to the wrong entry.
- A lost or stray mode bit flips the legality of the very next access, so `bad_access` rises where it should not.
- A mode bit that was set too early or cleared too late also shows up in bit 7 of configuration entry 18.
- A dropped or misaligned PROM write shows up only on a later PROM read of those bytes.

The checks therefore read state back right after every write, after illegal accesses, and after each reset.

// File: rtl/hrw_pkg.sv
package hrw_pkg;
  typedef enum logic [2:0] {
    T_NONE, T_PROM, T_DATA, T_PTR, T_RST, T_CFG
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic legal;
    logic to_dw;
    logic hi;
  } dec_t;

  function automatic tgt_e port_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return T_DATA;
      2'd1:    return T_PTR;
      2'd2:    return T_RST;
      default: return T_CFG;
    endcase
  endfunction
endpackage

// File: rtl/hrw_decode.sv
module hrw_decode
  import hrw_pkg::*;
(
  input  logic       dw_mode,
  input  logic       write,
  input  logic [4:0] off,
  input  logic [3:0] be_n,
  output dec_t       dec
);
  always_comb begin
    dec = '{tgt: T_NONE, legal: 1'b0, to_dw: 1'b0, hi: 1'b0};
    if (!dw_mode) begin
      if (!off[4]) begin
        dec.tgt = T_PROM;
        if (!write && be_n == ~(4'b0001 << off[1:0])) dec.legal = 1'b1;
        else if (off[1:0] == 2'b00 && be_n == 4'b1100) dec.legal = 1'b1;
        else if (off[1:0] == 2'b10 && be_n == 4'b0011) begin
          dec.legal = 1'b1;
          dec.hi    = 1'b1;
        end
      end else if (!off[3] && !off[0]) begin
        dec.tgt = port_of(off[2:1]);
        if (!off[1] && be_n == 4'b1100) dec.legal = 1'b1;
        else if (off[1] && be_n == 4'b0011) begin
          dec.legal = 1'b1;
          dec.hi    = 1'b1;
        end else if (off[2:1] == 2'b00 && write && be_n == 4'b0000) begin
          dec.legal = 1'b1;
          dec.to_dw = 1'b1;
        end
      end
    end else if (off[1:0] == 2'b00 && be_n == 4'b0000) begin
      if (!off[4]) begin
        dec.tgt   = T_PROM;
        dec.legal = !write;
      end else begin
        dec.tgt   = port_of(off[3:2]);
        dec.legal = 1'b1;
      end
    end
    if (!dec.legal) dec.tgt = T_NONE;
  end

  // R7
  always_comb begin
    if (dw_mode && dec.legal) dw_full_width_chk: assert (be_n == 4'b0000);
  end
endmodule

// File: rtl/hrw_regfile.sv
module hrw_regfile #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit;
    assign hit = we && (widx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[i] <= '0;
      else if (clr)    mem_q[i] <= '0;
      else if (hit)    mem_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ridx == IDX_W'(i)) rdata = mem_q[i];
  end
endmodule

// File: rtl/hostreg_window.sv
module hostreg_window
  import hrw_pkg::*;
#(
  parameter int         PTR_W      = 7,
  parameter int         CTRL_DEPTH = 8,
  parameter int         CFG_DEPTH  = 32,
  parameter logic [7:0] PROM_BASE  = 8'hA0,
  parameter int         MODE_REG   = 18,
  parameter int         MODE_BIT   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [4:0]  acc_offset,
  input  logic [3:0]  acc_be_n,
  input  logic [31:0] acc_wdata,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        bad_access,
  output logic        soft_reset,
  output logic        dw_mode
);
  localparam int PROM_BYTES = 16;
  localparam int REG_W      = 16;
  localparam logic [PTR_W-1:0] MODE_IDX = PTR_W'(MODE_REG);

  dec_t             dec;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             dw_q, dw_d;
  logic [7:0]       prom_q [PROM_BYTES];
  logic [7:0]       prom_d [PROM_BYTES];
  logic             soft_d, ctrl_we, cfg_we, take;
  logic [REG_W-1:0] ctrl_rd, cfg_rd, cfg_val, reg_val, wsel;
  logic [31:0]      rdat_d, rd_data_q;
  logic             rd_valid_q, bad_q, srst_q;

  hrw_decode i_decode (
    .dw_mode (dw_q),
    .write   (acc_write),
    .off     (acc_offset),
    .be_n    (acc_be_n),
    .dec     (dec)
  );

  hrw_regfile #(.DEPTH(CTRL_DEPTH), .WIDTH(REG_W), .IDX_W(PTR_W)) i_ctrl_file (
    .clk, .rst_n, .clr(soft_d), .we(ctrl_we), .widx(ptr_q), .wdata(wsel),
    .ridx(ptr_q), .rdata(ctrl_rd)
  );

  hrw_regfile #(.DEPTH(CFG_DEPTH), .WIDTH(REG_W), .IDX_W(PTR_W)) i_cfg_file (
    .clk, .rst_n, .clr(soft_d), .we(cfg_we), .widx(ptr_q), .wdata(wsel),
    .ridx(ptr_q), .rdata(cfg_rd)
  );

  assign take = acc_valid && dec.legal;
  assign wsel = dec.hi ? acc_wdata[31:16] : acc_wdata[15:0];

  // read path
  always_comb begin
    cfg_val = cfg_rd;
    if (ptr_q == MODE_IDX) cfg_val[MODE_BIT] = dw_q;
    case (dec.tgt)
      T_DATA:  reg_val = ctrl_rd;
      T_PTR:   reg_val = REG_W'(ptr_q);
      T_CFG:   reg_val = cfg_val;
      default: reg_val = '0;
    endcase
    rdat_d = '0;
    if (take && !acc_write) begin
      if (dec.tgt == T_PROM) begin
        for (int l = 0; l < 4; l++)
          if (!acc_be_n[l]) rdat_d[8*l +: 8] = prom_q[{acc_offset[3:2], 2'(l)}];
      end else begin
        rdat_d = dec.hi ? {reg_val, 16'h0} : {16'h0, reg_val};
      end
    end
  end

  // next state
  always_comb begin
    ptr_d   = ptr_q;
    dw_d    = dw_q;
    prom_d  = prom_q;
    soft_d  = 1'b0;
    ctrl_we = 1'b0;
    cfg_we  = 1'b0;
    if (take) begin
      case (dec.tgt)
        T_PROM: if (acc_write) begin
          for (int l = 0; l < 4; l++)
            if (!acc_be_n[l]) prom_d[{acc_offset[3:2], 2'(l)}] = acc_wdata[8*l +: 8];
        end
        T_DATA: begin
          ctrl_we = acc_write;
          if (dec.to_dw) dw_d = 1'b1;
        end
        T_PTR:  if (acc_write) ptr_d = wsel[PTR_W-1:0];
        T_RST:  soft_d = !acc_write;
        T_CFG:  cfg_we = acc_write;
        default: ;
      endcase
    end
    if (soft_d) begin
      ptr_d = '0;
      dw_d  = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      dw_q       <= 1'b0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      bad_q      <= 1'b0;
      srst_q     <= 1'b0;
      for (int k = 0; k < PROM_BYTES; k++) prom_q[k] <= PROM_BASE + 8'(k);
    end else begin
      ptr_q      <= ptr_d;
      dw_q       <= dw_d;
      prom_q     <= prom_d;
      rd_data_q  <= rdat_d;
      rd_valid_q <= acc_valid && !acc_write;
      bad_q      <= acc_valid && !dec.legal;
      srst_q     <= soft_d;
    end
  end

  assign rd_data    = rd_data_q;
  assign rd_valid   = rd_valid_q;
  assign bad_access = bad_q;
  assign soft_reset = srst_q;
  assign dw_mode    = dw_q;

  // R8
  // dw_sticky_chk
  property p_dw_sticky;
    @(posedge clk) disable iff (!rst_n) $fell(dw_q) |-> srst_q;
  endproperty
  dw_sticky_chk: assert property (p_dw_sticky);

  // R6
  dw_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dw_q) |-> $past(acc_valid && acc_write && acc_offset == 5'h10 && acc_be_n == 4'b0000));

  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (ptr_q == '0 && !dw_q));

  // R10
  bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> (rd_data_q == '0 && !srst_q));

  // R11
  rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write |=> rd_valid_q);
endmodule

// File: tb/test_hostreg_window.sv
module test_hostreg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [4:0]  acc_offset = '0;
  logic [3:0]  acc_be_n = 4'hF;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid, bad_access, soft_reset, dw_mode;

  int checks = 0, failures = 0;

  typedef struct {
    logic        rd;
    logic [31:0] data;
    logic        bad;
    logic        srst;
    logic        dw;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  hostreg_window i_hostreg_window (
    .clk, .rst_n, .acc_valid, .acc_write, .acc_offset, .acc_be_n, .acc_wdata,
    .rd_data, .rd_valid, .bad_access, .soft_reset, .dw_mode
  );

  task automatic acc(input logic wr, input logic [4:0] off, input logic [3:0] be,
                     input logic [31:0] wd, input logic [31:0] xd, input logic xbad,
                     input logic xsr, input logic xdw, input string tag);
    exp_t e;
    e.rd = !wr; e.data = wr ? 32'h0 : xd; e.bad = xbad; e.srst = xsr; e.dw = xdw; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_offset = off; acc_be_n = be; acc_wdata = wd;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // monitor
  always begin
    @(posedge clk);
    if (acc_valid) begin
      #2;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R11 unexpected access result: actual=%h expected=none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rd_valid !== e.rd || (e.rd && rd_data !== e.data) || bad_access !== e.bad ||
            soft_reset !== e.srst || dw_mode !== e.dw) begin
          failures++;
          $display("FAIL %s actual rv=%b d=%h bad=%b sr=%b dw=%b expected rv=%b d=%h bad=%b sr=%b dw=%b",
                   e.tag, rd_valid, rd_data, bad_access, soft_reset, dw_mode,
                   e.rd, e.data, e.bad, e.srst, e.dw);
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dw_mode !== 1'b0 || rd_valid !== 1'b0 || bad_access !== 1'b0 || soft_reset !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0000", dw_mode, rd_valid, bad_access, soft_reset);
    end
    // word mode
    acc(0, 5'h12, 4'b0011, 0, 32'h0, 0, 0, 0, "R1 pointer after reset");
    acc(0, 5'h01, 4'b1101, 0, 32'h0000A100, 0, 0, 0, "R2 prom byte 1");
    acc(0, 5'h0E, 4'b1011, 0, 32'h00AE0000, 0, 0, 0, "R2 prom byte 14");
    acc(0, 5'h0B, 4'b0111, 0, 32'hAB000000, 0, 0, 0, "R2 prom byte 11");
    acc(0, 5'h01, 4'b1110, 0, 32'h0, 1, 0, 0, "R2 lane mismatch");
    acc(0, 5'h04, 4'b1100, 0, 32'h0000A5A4, 0, 0, 0, "R3 prom word read");
    acc(1, 5'h08, 4'b1100, 32'h00001234, 0, 0, 0, 0, "R3 prom word write");
    acc(0, 5'h08, 4'b1100, 0, 32'h00001234, 0, 0, 0, "R3 prom readback");
    acc(0, 5'h0A, 4'b0011, 0, 32'hABAA0000, 0, 0, 0, "R3 prom upper word");
    acc(1, 5'h12, 4'b0011, 32'h00030000, 0, 0, 0, 0, "R4 pointer write");
    acc(0, 5'h12, 4'b0011, 0, 32'h00030000, 0, 0, 0, "R4 pointer read");
    acc(1, 5'h10, 4'b1100, 32'h0000BEEF, 0, 0, 0, 0, "R4 data write");
    acc(0, 5'h10, 4'b1100, 0, 32'h0000BEEF, 0, 0, 0, "R4 data read");
    acc(1, 5'h12, 4'b0011, 32'h00120000, 0, 0, 0, 0, "R5 pointer 18");
    acc(1, 5'h16, 4'b0011, 32'h00F50000, 0, 0, 0, 0, "R5 cfg write");
    acc(0, 5'h16, 4'b0011, 0, 32'h00750000, 0, 0, 0, "R5 mode bit ignores write");
    acc(0, 5'h11, 4'b1100, 0, 32'h0, 1, 0, 0, "R10 odd offset");
    acc(1, 5'h12, 4'b0000, 32'h0, 0, 1, 0, 0, "R10 dword pointer write");
    acc(0, 5'h12, 4'b0011, 0, 32'h00120000, 0, 0, 0, "R10 pointer unchanged");
    acc(0, 5'h18, 4'b1100, 0, 32'h0, 1, 0, 0, "R10 reserved");
    acc(0, 5'h00, 4'b0000, 0, 32'h0, 1, 0, 0, "R10 dword prom read in word mode");
    // enter 32-bit mode
    acc(1, 5'h12, 4'b0011, 32'h0, 0, 0, 0, 0, "R6 pointer 0");
    acc(1, 5'h10, 4'b0000, 32'h0, 0, 0, 0, 1, "R6 dword write sets mode");
    acc(0, 5'h14, 4'b0000, 0, 32'h0, 0, 0, 1, "R7 pointer at 14h");
    acc(1, 5'h14, 4'b0000, 32'h00000012, 0, 0, 0, 1, "R7 pointer write");
    acc(0, 5'h1C, 4'b0000, 0, 32'h000000F5, 0, 0, 1, "R5 R7 cfg mode bit");
    acc(0, 5'h04, 4'b0000, 0, 32'hA7A6A5A4, 0, 0, 1, "R7 prom dword");
    acc(0, 5'h12, 4'b0011, 0, 32'h0, 1, 0, 1, "R8 word access in dw");
    acc(1, 5'h00, 4'b0000, 32'hFFFFFFFF, 0, 1, 0, 1, "R8 prom write in dw");
    acc(0, 5'h16, 4'b0000, 0, 32'h0, 1, 0, 1, "R8 misaligned dword");
    acc(1, 5'h14, 4'b0000, 32'h0, 0, 0, 0, 1, "R8 pointer 0");
    acc(1, 5'h10, 4'b0000, 32'h00000004, 0, 0, 0, 1, "R8 stop bit keeps mode");
    acc(0, 5'h10, 4'b0000, 0, 32'h00000004, 0, 0, 1, "R8 csr0 readback");
    acc(1, 5'h18, 4'b0000, 32'hFFFFFFFF, 0, 0, 0, 1, "R9 reset write no effect");
    acc(0, 5'h18, 4'b0000, 0, 32'h0, 0, 1, 0, "R9 reset read");
    acc(0, 5'h12, 4'b0011, 0, 32'h0, 0, 0, 0, "R9 pointer cleared");
    acc(1, 5'h12, 4'b0011, 32'h00030000, 0, 0, 0, 0, "R9 pointer 3");
    acc(0, 5'h10, 4'b1100, 0, 32'h0, 0, 0, 0, "R9 ctrl file cleared");
    acc(0, 5'h08, 4'b1110, 0, 32'h00000034, 0, 0, 0, "R9 prom kept");
    idle();
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R11 pending results actual=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule